// File: doc/BRIEF.md
# Priority Interrupt Controller with Two-Pulse Acknowledge

The block gathers eight interrupt request lines and keeps one pending bit per line. It picks the most urgent pending line and raises a single interrupt output to the processor. The processor obtains the handler vector through a two-pulse acknowledge handshake. The first pulse moves the chosen request into the in-service set and removes it from the pending set. The second pulse puts an 8-bit vector on the vector bus. The vector is a programmable 5-bit base followed by the 3-bit line number.

A small register port carries commands, a mask, the vector base and status reads. Software that cannot issue acknowledge pulses arms a poll with one command write. The next command-address read then returns the winning line and grants it, exactly as a first acknowledge pulse would. Software can also read the raw pending register and dispatch by hand. The end-of-interrupt command retires the most urgent in-service line.

The acknowledge controller is a three-state machine:
- `ST_IDLE` moves to `ST_ACK_WAIT` on an acknowledge pulse (grant), and to `ST_POLL_ARMED` on a poll command.
- `ST_ACK_WAIT` returns to `ST_IDLE` on the second pulse, which delivers the vector.
- `ST_POLL_ARMED` returns to `ST_IDLE` on a command-address read (poll grant). An acknowledge pulse in this state moves it to `ST_ACK_WAIT`, and the poll is dropped.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A rising edge on line i sets pending bit i when mask bit i is clear. A rising edge while the mask bit is set is not latched. A line held high does not set the bit again after the bit is cleared.
- R2: `irq_out` is high exactly when some pending bit has its mask bit clear.
- R3: On a first acknowledge pulse, the winner is the lowest-numbered unmasked pending line whose number is lower than every in-service line. The winner's in-service bit is set and its pending bit is cleared.
- R4: On the second acknowledge pulse, `vec_out` becomes {base[7:3], level[2:0]} and `vec_valid` is high for exactly one cycle.
- R5: A first pulse with no eligible winner is spurious. The second pulse then delivers level 7, and the pending and in-service registers stay as they were.
- R6: Writing 0x0C to address 0 arms a poll. The next read of address 0 returns 0x80 | level and grants as in R3, or returns 0x00 when no line is eligible. That read disarms the poll.
- R7: Outside a poll, a read of address 0 returns the pending register. Command 0x0B switches that read to the in-service register, and 0x0A switches it back to the pending register.
- R8: Writing 0x20 to address 0 clears the lowest-numbered set in-service bit.
- R9: Address 1 writes and reads the mask (1 = masked). Address 2 writes the vector base from bits 7:3 and reads back with bits 2:0 zero. Address 3 reads 0x00.
- R10: After reset, pending, in-service, mask and base are all zero, and `irq_out`, `vec_valid` and `reg_rdata` are 0.
- R11: A line of equal or lower priority than an in-service line is not granted while that line is in service.
- R12: A pending bit whose mask bit becomes set is kept but not signalled. Clearing the mask signals it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 8 | Request lines, edge-sensitive |
| ack_pulse | input | 1 | One-cycle acknowledge pulse from the processor side |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data is registered and appears after the edge |
| reg_addr | input | 2 | Register address: 0 command/status, 1 mask, 2 vector base |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| irq_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Handler vector |
| vec_valid | output | 1 | One-cycle strobe marking a new vector |

## Verification
The hardest case to reach is the spurious acknowledge. It needs a request that raises `irq_out` while an equal-or-higher line already sits in service. The stimulus first grants line 5 and leaves it in service, then pulses line 6. An acknowledge pair at that point must return level 7 and leave both registers unchanged. The poll path is driven both with a pending line and with nothing pending, and a following plain read shows that the poll is disarmed.

// File: rtl/pic_pkg.sv
package pic_pkg;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_ACK_WAIT   = 2'd1,
        ST_POLL_ARMED = 2'd2
    } ack_state_e;

    localparam logic [7:0] CMD_POLL    = 8'h0C;
    localparam logic [7:0] CMD_EOI     = 8'h20;
    localparam logic [7:0] CMD_SEL_REQ = 8'h0A;
    localparam logic [7:0] CMD_SEL_ISR = 8'h0B;

    localparam logic [1:0] RA_CMD  = 2'd0;
    localparam logic [1:0] RA_MASK = 2'd1;
    localparam logic [1:0] RA_BASE = 2'd2;

endpackage

// File: rtl/pic_edge_latch.sv
module pic_edge_latch #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lines,
    input  logic [N-1:0] mask,
    input  logic [N-1:0] clr,
    output logic [N-1:0] req
);

    logic [N-1:0] prev_q;
    logic [N-1:0] req_q;
    logic [N-1:0] rise;

    assign rise = lines & ~prev_q & ~mask;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            req_q  <= '0;
        end else begin
            prev_q <= lines;
            req_q  <= (req_q & ~clr) | rise;
        end
    end

    assign req = req_q;

    for (genvar g = 0; g < N; g++) begin : g_bit
        assert_edge_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (lines[g] && !prev_q[g] && !mask[g]) |=> req_q[g]);
    end

endmodule

// File: rtl/pic_resolver.sv
module pic_resolver #(
    parameter int unsigned N  = 8,
    parameter int unsigned LW = 3
) (
    input  logic [N-1:0]  req,
    input  logic [N-1:0]  mask,
    input  logic [N-1:0]  isr,
    output logic          win_valid,
    output logic [LW-1:0] win_lvl,
    output logic          any_pending,
    output logic [N-1:0]  eoi_clr
);

    logic [N-1:0] pend;

    assign pend        = req & ~mask;
    assign any_pending = |pend;
    assign eoi_clr     = isr & (~isr + N'(1));

    always_comb begin
        logic blocked;
        blocked   = 1'b0;
        win_valid = 1'b0;
        win_lvl   = '0;
        for (int i = 0; i < N; i++) begin
            if (!win_valid && !blocked) begin
                if (isr[i]) begin
                    blocked = 1'b1;
                end else if (pend[i]) begin
                    win_valid = 1'b1;
                    win_lvl   = LW'(i);
                end
            end
        end
    end

endmodule

// File: rtl/pic_ack_fsm.sv
module pic_ack_fsm
    import pic_pkg::*;
#(
    parameter int unsigned N  = 8,
    parameter int unsigned LW = 3,
    parameter int unsigned VW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack,
    input  logic             poll_cmd,
    input  logic             poll_rd,
    input  logic             eoi,
    input  logic             win_valid,
    input  logic [LW-1:0]    win_lvl,
    input  logic [N-1:0]     eoi_clr,
    input  logic [VW-LW-1:0] base_hi,
    output logic [N-1:0]     isr,
    output logic [N-1:0]     grant_clr,
    output logic             poll_armed,
    output logic [VW-1:0]    poll_byte,
    output logic [VW-1:0]    vec_out,
    output logic             vec_valid
);

    ack_state_e    state_q, state_d;
    logic [N-1:0]  isr_q;
    logic [LW-1:0] held_q;
    logic [VW-1:0] vec_q;
    logic          vec_v_q;
    logic          take_ack, take_poll, grant_ok, second_pulse;

    assign take_ack     = ack && (state_q != ST_ACK_WAIT);
    assign take_poll    = (state_q == ST_POLL_ARMED) && poll_rd && !ack;
    assign grant_ok     = (take_ack || take_poll) && win_valid;
    assign second_pulse = ack && (state_q == ST_ACK_WAIT);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ack)           state_d = ST_ACK_WAIT;
                else if (poll_cmd) state_d = ST_POLL_ARMED;
            end
            ST_ACK_WAIT: begin
                if (ack)           state_d = ST_IDLE;
            end
            ST_POLL_ARMED: begin
                if (ack)           state_d = ST_ACK_WAIT;
                else if (poll_rd)  state_d = ST_IDLE;
            end
            default:               state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q   <= '0;
            held_q  <= '0;
            vec_q   <= '0;
            vec_v_q <= 1'b0;
        end else begin
            isr_q   <= (isr_q & ~(eoi ? eoi_clr : '0)) | grant_clr;
            vec_v_q <= second_pulse;
            if (take_ack)
                held_q <= win_valid ? win_lvl : LW'(N - 1);
            if (second_pulse)
                vec_q <= {base_hi, held_q};
        end
    end

    assign grant_clr  = grant_ok ? (N'(1) << win_lvl) : '0;
    assign isr        = isr_q;
    assign poll_armed = (state_q == ST_POLL_ARMED);
    assign poll_byte  = win_valid ? {1'b1, {(VW-1-LW){1'b0}}, win_lvl} : '0;
    assign vec_out    = vec_q;
    assign vec_valid  = vec_v_q;

    assert_vec_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        vec_v_q |=> !vec_v_q);
    assert_grant_adds_isr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_ok && !eoi) |=> ($countones(isr_q) == $past($countones(isr_q)) + 1));
    assert_spurious_keeps_isr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take_ack && !win_valid && !eoi) |=> $stable(isr_q));
    assert_eoi_drops_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !grant_ok && (isr_q != '0)) |=> ($countones(isr_q) == $past($countones(isr_q)) - 1));
    assert_poll_disarm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take_poll |=> (state_q == ST_IDLE));

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter int unsigned N_LINES = 8,
    parameter int unsigned VEC_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_lines,
    input  logic               ack_pulse,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [1:0]         reg_addr,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    output logic               irq_out,
    output logic [VEC_W-1:0]   vec_out,
    output logic               vec_valid
);

    localparam int unsigned LVL_W  = $clog2(N_LINES);
    localparam int unsigned BASE_W = VEC_W - LVL_W;

    logic [N_LINES-1:0] mask_q, req, isr, grant_clr, eoi_clr;
    logic [BASE_W-1:0]  base_q;
    logic               sel_isr_q;
    logic [7:0]         rdata_q;
    logic               win_valid, any_pending, poll_armed;
    logic [LVL_W-1:0]   win_lvl;
    logic [VEC_W-1:0]   poll_byte;
    logic               cmd_wr, poll_cmd, eoi, poll_rd;

    assign cmd_wr   = reg_wr && (reg_addr == RA_CMD);
    assign poll_cmd = cmd_wr && (reg_wdata == CMD_POLL);
    assign eoi      = cmd_wr && (reg_wdata == CMD_EOI);
    assign poll_rd  = reg_rd && (reg_addr == RA_CMD);

    pic_edge_latch #(.N(N_LINES)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .lines (irq_lines),
        .mask  (mask_q),
        .clr   (grant_clr),
        .req   (req)
    );

    pic_resolver #(.N(N_LINES), .LW(LVL_W)) u_resolve (
        .req         (req),
        .mask        (mask_q),
        .isr         (isr),
        .win_valid   (win_valid),
        .win_lvl     (win_lvl),
        .any_pending (any_pending),
        .eoi_clr     (eoi_clr)
    );

    pic_ack_fsm #(.N(N_LINES), .LW(LVL_W), .VW(VEC_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ack        (ack_pulse),
        .poll_cmd   (poll_cmd),
        .poll_rd    (poll_rd),
        .eoi        (eoi),
        .win_valid  (win_valid),
        .win_lvl    (win_lvl),
        .eoi_clr    (eoi_clr),
        .base_hi    (base_q),
        .isr        (isr),
        .grant_clr  (grant_clr),
        .poll_armed (poll_armed),
        .poll_byte  (poll_byte),
        .vec_out    (vec_out),
        .vec_valid  (vec_valid)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q    <= '0;
            base_q    <= '0;
            sel_isr_q <= 1'b0;
        end else if (reg_wr) begin
            if (reg_addr == RA_MASK) mask_q <= reg_wdata[N_LINES-1:0];
            if (reg_addr == RA_BASE) base_q <= reg_wdata[7 -: BASE_W];
            if (cmd_wr && reg_wdata == CMD_SEL_ISR) sel_isr_q <= 1'b1;
            if (cmd_wr && reg_wdata == CMD_SEL_REQ) sel_isr_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (reg_rd) begin
            case (reg_addr)
                RA_CMD: begin
                    if (poll_armed && !ack_pulse) rdata_q <= 8'(poll_byte);
                    else if (sel_isr_q)           rdata_q <= 8'(isr);
                    else                          rdata_q <= 8'(req);
                end
                RA_MASK: rdata_q <= 8'(mask_q);
                RA_BASE: rdata_q <= 8'({base_q, {LVL_W{1'b0}}});
                default: rdata_q <= '0;
            endcase
        end
    end

    assign reg_rdata = rdata_q;
    assign irq_out   = any_pending;

endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_lines = '0;
    logic       ack_pulse = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata, vec_out;
    logic       irq_out, vec_valid;

    always #4 clk = ~clk;

    prio_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .ack_pulse(ack_pulse),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_out(irq_out), .vec_out(vec_out), .vec_valid(vec_valid)
    );

    typedef struct { string tag; logic [7:0] val; bit is_vec; } exp_t;
    exp_t exp_q[$];
    int   compared = 0, mismatched = 0;
    logic rd_d = 1'b0;
    bit   done = 1'b0;

    always @(posedge clk) rd_d <= reg_rd;

    task automatic pop_cmp(bit isv, logic [7:0] act);
        exp_t e;
        compared++;
        if (exp_q.size() == 0) begin
            mismatched++;
            $display("FAIL unexpected %s output act=%02h exp=none", isv ? "vector" : "read", act);
        end else begin
            e = exp_q.pop_front();
            if (e.is_vec != isv || e.val !== act) begin
                mismatched++;
                $display("FAIL %s act=%02h exp=%02h", e.tag, act, e.val);
            end
        end
    endtask

    always @(negedge clk) begin
        if (rd_d === 1'b1)     pop_cmp(1'b0, reg_rdata);
        if (vec_valid === 1'b1) pop_cmp(1'b1, vec_out);
    end

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, logic [7:0] exp, string tag);
        exp_q.push_back('{tag, exp, 1'b0});
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic pulse(int line);
        @(negedge clk); irq_lines[line] = 1'b1;
        @(negedge clk); irq_lines[line] = 1'b0;
    endtask

    task automatic ack_pair(logic [7:0] exp, string tag);
        @(negedge clk); ack_pulse = 1'b1;
        @(negedge clk); ack_pulse = 1'b0;
        exp_q.push_back('{tag, exp, 1'b1});
        @(negedge clk); ack_pulse = 1'b1;
        @(negedge clk); ack_pulse = 1'b0;
    endtask

    task automatic chk_irq(logic exp, string tag);
        @(negedge clk);
        check(tag, {7'b0, irq_out}, {7'b0, exp});
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog expired act=running exp=finished");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset irq_out", {7'b0, irq_out}, 8'h00);
        check("R10 reset vec_valid", {7'b0, vec_valid}, 8'h00);
        check("R10 reset rdata", reg_rdata, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        rd(2'd0, 8'h00, "R10 pending after reset");
        rd(2'd1, 8'h00, "R10 mask after reset");

        wr(2'd2, 8'h4B);
        rd(2'd2, 8'h48, "R9 base readback");

        // line 5 raised and held high
        @(negedge clk); irq_lines[5] = 1'b1;
        chk_irq(1'b1, "R2 irq_out with line 5 pending");
        rd(2'd0, 8'h20, "R7 pending register read");
        ack_pair(8'h4D, "R4 vector for line 5");
        rd(2'd0, 8'h00, "R3 pending cleared on grant");
        chk_irq(1'b0, "R2 irq_out low after grant");
        wr(2'd0, 8'h0B);
        rd(2'd0, 8'h20, "R3 in-service bit 5 set");
        wr(2'd0, 8'h0A);
        rd(2'd0, 8'h00, "R1 held line does not relatch");
        @(negedge clk); irq_lines[5] = 1'b0;

        // lower-priority line 6 while 5 in service
        pulse(6);
        chk_irq(1'b1, "R2 irq_out with line 6 pending");
        ack_pair(8'h4F, "R5 spurious vector level 7");
        rd(2'd0, 8'h40, "R11 line 6 stays pending");
        wr(2'd0, 8'h0B);
        rd(2'd0, 8'h20, "R5 in-service unchanged by spurious");

        // higher-priority line 2 nests
        pulse(2);
        ack_pair(8'h4A, "R3 line 2 preempts in-service 5");
        rd(2'd0, 8'h24, "R3 nested in-service");
        wr(2'd0, 8'h20);
        rd(2'd0, 8'h20, "R8 EOI clears line 2 first");
        wr(2'd0, 8'h20);
        rd(2'd0, 8'h00, "R8 EOI clears line 5");

        // poll path
        wr(2'd0, 8'h0C);
        rd(2'd0, 8'h86, "R6 poll returns line 6");
        rd(2'd0, 8'h40, "R6 poll grant sets in-service");
        wr(2'd0, 8'h0A);
        rd(2'd0, 8'h00, "R6 poll grant clears pending");
        chk_irq(1'b0, "R2 irq_out low after poll");
        wr(2'd0, 8'h0C);
        rd(2'd0, 8'h00, "R6 empty poll");
        pulse(3);
        rd(2'd0, 8'h08, "R6 poll disarmed after one read");
        wr(2'd0, 8'h20);

        // masking
        wr(2'd1, 8'h0A);
        rd(2'd1, 8'h0A, "R9 mask readback");
        chk_irq(1'b0, "R12 masked pending not signalled");
        pulse(1);
        rd(2'd0, 8'h08, "R1 masked edge not latched");
        wr(2'd1, 8'h00);
        chk_irq(1'b1, "R12 unmask signals again");
        ack_pair(8'h4B, "R3 vector for line 3");
        rd(2'd0, 8'h00, "R3 pending empty");
        rd(2'd3, 8'h00, "R9 unused address");

        repeat (4) @(negedge clk);
        check("queue drained", 8'(exp_q.size()), 8'h00);
        done = 1'b1;
        summary();
    end

endmodule